// File: doc/BRIEF.md
# Programmable Card Transfer Clock Generator

This block turns a peripheral clock into the serial transfer clock for a memory-card interface. An 8-bit control register holds two settings. One bit switches the card clock on or off. A 3-bit code selects a divide ratio of 100, 8, 4 or 2, or passes the peripheral clock through unchanged. The slowest ratio is meant for the card identification phase. Pass-through gives the fastest rate: with a 20 MHz peripheral clock it produces a 20 Mbps transfer clock.

Software writes the register at any time. A write that arrives while the interface controller reports a command in progress is stored and can be read back at once. It does not reach the clock until the command ends. New settings are applied only at the start of a low phase, so the pin never shows a shortened pulse.

A four-state machine drives the output:
- OFF holds the pin low.
- LOW and HIGH count the two halves of a divided period.
- PASS hands the pin to a glitch-free gate on the peripheral clock.

Its transitions are:
- OFF to LOW or PASS when the clock is enabled.
- LOW to HIGH when the low half expires.
- HIGH to LOW when the high half expires.
- HIGH to OFF or PASS when a pending change is applied at that boundary.
- PASS to OFF or LOW when a pending change is applied.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, the register reads 0x00, the error flag reads 0 and the card clock is low.
- R2: With the enable bit (bit 7) at 0, the card clock stays low.
- R3: Select code (bits 2..0) 000 divides by 100, 001 by 8, 010 by 4, 011 by 2. The output's high and low phases last 50, 4, 2 and 1 peripheral cycles respectively.
- R4: Bits 6..3 always read 0, whatever was written to them.
- R5: A write with select code 101, 110 or 111 leaves the stored select code unchanged, still updates bit 7, and sets a sticky error flag (rd_err) that only reset clears.
- R6: Every divided output has equal high and low phase lengths.
- R7: While cmd_busy is high, writes are stored and read back, but the applied enable and ratio do not change. They take effect only after cmd_busy falls.
- R8: Select code 100 with the clock enabled passes the peripheral clock through. The output is high while clk is high and low while clk is low, gated by an enable latched during clk low.
- R9: Changes to the enable or the ratio are applied only at the start of a low phase. Every high pulse of a divided output therefore lasts a full 50, 4, 2 or 1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value (stored settings) |
| rd_err | output | 1 | Sticky flag for a prohibited select code |
| cmd_busy | input | 1 | High while a card command is in progress |
| card_clk | output | 1 | Card transfer clock output |

## Verification
Two functions can meet in the same cycle. One is the hold of pending settings during a command. The other is the phase-boundary update that applies them. A settings write can therefore land on the very cycle a high phase expires, or cmd_busy can fall on that cycle. The bench provokes this with writes at random offsets inside running periods and with directed busy windows that straddle a boundary. It judges the result with a monitor that requires every sampled high pulse to last a legal full half-period, and by measuring the old ratio before busy falls and the new ratio after.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_PASS = 2'd3
    } ccg_state_e;
endpackage

// File: rtl/ccg_cfg_regs.sv
module ccg_cfg_regs #(
    parameter int REG_W   = 8,
    parameter int SEL_W   = 3,
    parameter int EN_BIT  = 7,
    parameter int MAX_SEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             pend_en,
    output logic [SEL_W-1:0] pend_sel,
    output logic             err
);
    logic [SEL_W-1:0] code;
    logic             bad_code;

    assign code     = wr_data[SEL_W-1:0];
    assign bad_code = (code > SEL_W'(MAX_SEL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_en  <= 1'b0;
            pend_sel <= '0;
            err      <= 1'b0;
        end else if (wr_en) begin
            pend_en <= wr_data[EN_BIT];
            if (bad_code) begin
                err <= 1'b1;
            end else begin
                pend_sel <= code;
            end
        end
    end
endmodule

// File: rtl/ccg_div_fsm.sv
module ccg_div_fsm
    import ccg_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int SLOW_HALF = 50,
    parameter int PASS_CODE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_busy,
    input  logic             pend_en,
    input  logic [SEL_W-1:0] pend_sel,
    output logic             out_q,
    output logic             pass_q,
    output logic             act_en,
    output logic [SEL_W-1:0] act_sel
);
    localparam int CNT_W = $clog2(SLOW_HALF + 1);

    ccg_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [SEL_W-1:0] sel_n;
    logic             en_n;
    logic             apply_ok;
    logic             cfg_diff;

    function automatic logic [CNT_W-1:0] half_len(input logic [SEL_W-1:0] s);
        case (s)
            SEL_W'(0): half_len = CNT_W'(SLOW_HALF);
            SEL_W'(1): half_len = CNT_W'(4);
            SEL_W'(2): half_len = CNT_W'(2);
            default:   half_len = CNT_W'(1);
        endcase
    endfunction

    assign apply_ok = !cmd_busy;
    assign cfg_diff = (pend_en != act_en) || (pend_sel != act_sel);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sel_n   = act_sel;
        en_n    = act_en;
        unique case (state)
            ST_OFF: begin
                if (apply_ok) begin
                    sel_n = pend_sel;
                    en_n  = pend_en;
                    if (pend_en) begin
                        if (pend_sel == SEL_W'(PASS_CODE)) begin
                            state_n = ST_PASS;
                        end else begin
                            state_n = ST_LOW;
                            cnt_n   = half_len(pend_sel) - CNT_W'(1);
                        end
                    end
                end
            end
            ST_LOW: begin
                if (cnt == '0) begin
                    state_n = ST_HIGH;
                    cnt_n   = half_len(act_sel) - CNT_W'(1);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (cnt != '0) begin
                    cnt_n = cnt - CNT_W'(1);
                end else if (apply_ok) begin
                    sel_n = pend_sel;
                    en_n  = pend_en;
                    if (!pend_en) begin
                        state_n = ST_OFF;
                    end else if (pend_sel == SEL_W'(PASS_CODE)) begin
                        state_n = ST_PASS;
                    end else begin
                        state_n = ST_LOW;
                        cnt_n   = half_len(pend_sel) - CNT_W'(1);
                    end
                end else begin
                    state_n = ST_LOW;
                    cnt_n   = half_len(act_sel) - CNT_W'(1);
                end
            end
            ST_PASS: begin
                if (apply_ok && cfg_diff) begin
                    sel_n = pend_sel;
                    en_n  = pend_en;
                    if (!pend_en) begin
                        state_n = ST_OFF;
                    end else begin
                        state_n = ST_LOW;
                        cnt_n   = half_len(pend_sel) - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            act_sel <= '0;
            act_en  <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            act_sel <= sel_n;
            act_en  <= en_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            out_q  <= (state_n == ST_HIGH);
            pass_q <= (state_n == ST_PASS);
        end
    end
endmodule

// File: rtl/ccg_clk_gate.sv
module ccg_clk_gate (
    input  logic clk,
    input  logic pass_q,
    input  logic out_q,
    output logic card_clk
);
    logic gate_lat;

    always_latch begin
        if (!clk) begin
            gate_lat = pass_q;
        end
    end

    assign card_clk = out_q | (clk & gate_lat);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
    parameter int REG_W     = 8,
    parameter int SEL_W     = 3,
    parameter int SLOW_HALF = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_err,
    input  logic             cmd_busy,
    output logic             card_clk
);
    localparam int EN_BIT    = REG_W - 1;
    localparam int RSV_W     = REG_W - 1 - SEL_W;
    localparam int PASS_CODE = 4;

    logic             pend_en;
    logic [SEL_W-1:0] pend_sel;
    logic             act_en;
    logic [SEL_W-1:0] act_sel;
    logic             out_q;
    logic             pass_q;

    ccg_cfg_regs #(
        .REG_W  (REG_W),
        .SEL_W  (SEL_W),
        .EN_BIT (EN_BIT),
        .MAX_SEL(PASS_CODE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pend_en (pend_en),
        .pend_sel(pend_sel),
        .err     (rd_err)
    );

    ccg_div_fsm #(
        .SEL_W    (SEL_W),
        .SLOW_HALF(SLOW_HALF),
        .PASS_CODE(PASS_CODE)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_busy(cmd_busy),
        .pend_en (pend_en),
        .pend_sel(pend_sel),
        .out_q   (out_q),
        .pass_q  (pass_q),
        .act_en  (act_en),
        .act_sel (act_sel)
    );

    ccg_clk_gate u_gate (
        .clk     (clk),
        .pass_q  (pass_q),
        .out_q   (out_q),
        .card_clk(card_clk)
    );

    assign rd_data = {pend_en, {RSV_W{1'b0}}, pend_sel};
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       rd_err,
    input logic       cmd_busy,
    input logic       act_en,
    input logic [2:0] act_sel,
    input logic       out_q
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:3] == 4'd0); // R4

    AST_BAD_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2:0] > 3'd4) |=> $stable(rd_data[2:0])); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> rd_err); // R5

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> ($stable(act_sel) && $stable(act_en))); // R7

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> !out_q); // R2

    AST_APPLY_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_sel) || !$stable(act_en)) |-> !out_q); // R9

    AST_PASS_NO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && act_sel == 3'd4) |-> !out_q); // R8

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_sel <= 3'd4); // R5
endmodule

bind card_clk_gen ccg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rd_err  (rd_err),
    .cmd_busy(cmd_busy),
    .act_en  (act_en),
    .act_sel (act_sel),
    .out_q   (out_q)
);

// File: tb/tb_card_clk_gen.sv
module tb_card_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_err;
    logic       cmd_busy = 1'b0;
    logic       card_clk;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    card_clk_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rd_err  (rd_err),
        .cmd_busy(cmd_busy),
        .card_clk(card_clk)
    );

    function automatic int exp_half(input logic [2:0] s);
        case (s)
            3'd0:    return 50;
            3'd1:    return 4;
            3'd2:    return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev, cur;
        int   g;
        prev = 1'b1; hi = 0; lo = 0;
        for (g = 0; g < 2000; g++) begin
            @(negedge clk); cur = card_clk;
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (card_clk) hi++; else break;
        end
        lo = 1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!card_clk) lo++; else break;
        end
    endtask

    // R9 monitor: every sampled high pulse lasts a full legal half-period
    int run_hi = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (card_clk) run_hi++;
            else if (run_hi != 0) begin
                check(run_hi == 1 || run_hi == 2 || run_hi == 4 || run_hi == 50,
                      "R9 high pulse length", run_hi, 0);
                run_hi = 0;
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, seen;
        logic [2:0] s;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
        check(rd_err == 1'b0, "R1 reset rd_err", rd_err, 0);
        check(card_clk == 1'b0, "R1 reset card_clk", card_clk, 0);

        // R4 reserved bits ignored
        reg_write(8'h7B);
        @(negedge clk);
        check(rd_data == 8'h03, "R4 reserved bits read 0", rd_data, 8'h03);

        // R2 disabled clock stays low
        seen = 0;
        repeat (120) begin @(negedge clk); if (card_clk) seen++; end
        check(seen == 0, "R2 off stays low", seen, 0);

        // R5 prohibited code
        reg_write(8'h85);
        @(negedge clk);
        check(rd_data == 8'h83, "R5 bad code keeps select", rd_data, 8'h83);
        check(rd_err == 1'b1, "R5 error flag set", rd_err, 1);
        reg_write(8'h81);
        @(negedge clk);
        check(rd_err == 1'b1, "R5 error flag sticky", rd_err, 1);

        // R3 R6 directed: every divided ratio
        for (int c = 0; c < 4; c++) begin
            reg_write({1'b1, 4'b0, c[2:0]});
            measure(hi, lo);
            measure(hi, lo);
            check(hi == exp_half(c[2:0]), "R3 high phase", hi, exp_half(c[2:0]));
            check(lo == hi, "R6 duty equal", lo, hi);
        end

        // R3 R6 R9 random: writes at random offsets
        for (int i = 0; i < 8; i++) begin
            s = 3'($urandom % 4);
            repeat ($urandom % 7) @(posedge clk);
            reg_write({1'b1, 4'($urandom), s});
            measure(hi, lo);
            measure(hi, lo);
            check(hi == exp_half(s), "R3 random ratio", hi, exp_half(s));
            check(lo == hi, "R6 random duty", lo, hi);
        end

        // R7 busy holds old ratio until release
        reg_write(8'h81);
        measure(hi, lo);
        #1 cmd_busy = 1'b1;
        reg_write(8'h83);
        @(negedge clk);
        check(rd_data == 8'h83, "R7 write stored while busy", rd_data, 8'h83);
        measure(hi, lo);
        measure(hi, lo);
        check(hi == 4, "R7 old ratio while busy", hi, 4);
        @(posedge clk); #1 cmd_busy = 1'b0;
        measure(hi, lo);
        measure(hi, lo);
        check(hi == 1, "R7 new ratio after busy", hi, 1);

        // R8 pass-through
        reg_write(8'h84);
        repeat (6) @(posedge clk);
        seen = 0;
        repeat (20) begin
            @(posedge clk); #2; if (card_clk !== 1'b1) seen++;
            @(negedge clk); #2; if (card_clk !== 1'b0) seen++;
        end
        check(seen == 0, "R8 pass-through follows clk", seen, 0);

        // R2 R7 disable requested while busy, applied after
        #1 cmd_busy = 1'b1;
        reg_write(8'h04);
        repeat (3) @(posedge clk); #2;
        check(card_clk == 1'b1, "R7 pass held while busy", card_clk, 1);
        @(posedge clk); #1 cmd_busy = 1'b0;
        repeat (4) @(posedge clk);
        seen = 0;
        repeat (60) begin
            @(posedge clk); #2; if (card_clk) seen++;
            @(negedge clk); #2; if (card_clk) seen++;
        end
        check(seen == 0, "R2 disabled after pass", seen, 0);

        // R3 slow rate restart from off
        reg_write(8'h80);
        measure(hi, lo);
        check(hi == 50 && lo == 50, "R3 slow identification rate", hi, 50);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule